// File: doc/BRIEF.md
# Fully Associative Byte Cache with Least-Recently-Used Replacement

This block sits between a processor load/store port and a block-wide main-memory port. Any memory block may be placed in any slot. An address has only two fields: the tag in the upper bits and the byte offset in the lower bits. A request's tag is compared with the tags of all slots in the same cycle. A hit is served from the slot. A miss brings the block in from memory. The new block goes into an empty slot if there is one; otherwise it replaces the slot that has gone longest without an access.

Each slot stores a valid flag, a dirty flag, a tag, a data block and a rank. Rank 0 marks the most recent slot. The parameter `WRITE_BACK` selects one of two write policies:
- When set, writes stay in the cache and mark the slot dirty. A dirty slot is copied to memory only when it is evicted, and a write miss first fetches the block.
- When clear, every write goes to memory as a single-byte masked write, and a write miss leaves the cache unchanged.

The processor asserts a request and holds it until a one-cycle ready pulse comes back. The memory side uses a plain request/ready handshake that moves one block per transfer.

Top module: `assoc_lru_cache`

## Requirements
- R1: The tag is `cpu_addr_i[ADDR_W-1:OFF_W]` and the offset is the low `OFF_W` bits. A read returns the byte at lane `offset`, where lane k occupies bits 8k+7..8k of a block word.
- R2: After reset, `cpu_ready_o` and `mem_req_o` are low and every slot is invalid, so the first access to any block is a miss.
- R3: A hit requires a slot that is valid and holds an equal tag. At most one slot matches a request.
- R4: A miss fills an invalid slot whenever one exists, so no block is evicted before all slots are occupied. From a cold cache, the reads 0,2,2,0,16,20,10,4 give exactly 5 misses.
- R5: On each hit, the accessed slot's rank becomes 0, and every valid slot with a lower rank than the accessed slot's old rank moves up by one. A newly filled slot is treated as the oldest until it is touched. When the cache is full, the victim is the slot of rank SLOTS-1. From a cold cache, the reads 0,2,4,10,20,16,0,2 give 6 misses, and address 16 evicts the block at 0.
- R6: In write-back mode, a write hit updates only the cache and marks the slot dirty. It produces no memory transfer. A dirty victim is written to memory as a whole block (all mask bits set) before the refill is read.
- R7: In write-back mode, a write miss fetches the block and then merges the byte. It completes with `cpu_hit_o` low, and memory keeps its old byte until that slot is evicted.
- R8: In write-through mode, each write causes exactly one memory write whose mask has only the addressed byte set. A write miss allocates no slot, and no slot ever becomes dirty.
- R9: `cpu_ready_o` is a one-cycle pulse that ends each request. `cpu_hit_o` tells whether the request was served without a block fetch. A read hit, or a write-back write hit, pulses ready in the cycle after the request is accepted.
- R10: `mem_req_o`, `mem_we_o` and `mem_addr_o` stay constant until `mem_ready_i` is seen. `mem_addr_o` is always block aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_i | input | 1 | Processor request, held until ready |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Byte address |
| cpu_wdata_i | input | 8 | Write byte |
| cpu_ready_o | output | 1 | One-cycle completion pulse |
| cpu_hit_o | output | 1 | Completed request hit without a fetch |
| cpu_rdata_o | output | 8 | Read byte, valid with ready |
| mem_req_o | output | 1 | Memory transfer request |
| mem_we_o | output | 1 | 1 = memory write, 0 = block read |
| mem_addr_o | output | ADDR_W | Block-aligned memory address |
| mem_wdata_o | output | 8*BLOCK_BYTES | Write block data |
| mem_wmask_o | output | BLOCK_BYTES | Byte enables for a memory write |
| mem_rdata_i | input | 8*BLOCK_BYTES | Read block data, valid with mem_ready_i |
| mem_ready_i | input | 1 | Memory transfer done |

## Verification
A corrupted rank does not show up at once. It stays hidden until the cache is full and a miss picks its victim; the error then appears as an extra miss several accesses later. For that reason, the two reference sequences are compared hit by hit against an independent recency-list model.

A lost or stuck dirty flag shows up as a missing or extra whole-block memory write at eviction time. After eviction, memory then holds a stale byte. A wrong tag or offset lane returns a wrong byte on the very next read, in the same ready cycle. A write-through slip shows at once in the memory write count and in memory contents.

// File: rtl/fa_cache_pkg.sv
package fa_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVICT = 2'd1,
    ST_FETCH = 2'd2,
    ST_WRITE = 2'd3
  } cache_state_e;
endpackage

// File: rtl/fa_tag_match.sv
module fa_tag_match #(
  parameter int SLOTS = 4,
  parameter int TAG_W = 4,
  parameter int IDX_W = $clog2(SLOTS)
) (
  input  logic [SLOTS-1:0]            valid_i,
  input  logic [SLOTS-1:0][TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]            tag_i,
  output logic [SLOTS-1:0]            hit_vec_o,
  output logic                        hit_o,
  output logic [IDX_W-1:0]            hit_idx_o,
  output logic                        free_o,
  output logic [IDX_W-1:0]            free_idx_o
);
  // parallel compare, one comparator per slot
  for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
    assign hit_vec_o[g] = valid_i[g] && (tags_i[g] == tag_i);
  end

  assign hit_o = |hit_vec_o;

  // encode the hit and pick the lowest-numbered invalid slot
  always_comb begin
    hit_idx_o  = '0;
    free_o     = 1'b0;
    free_idx_o = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (hit_vec_o[i]) hit_idx_o = IDX_W'(i);
      if (!valid_i[i]) begin
        free_o     = 1'b1;
        free_idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/fa_lru_rank.sv
module fa_lru_rank #(
  parameter int SLOTS = 4,
  parameter int IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SLOTS-1:0] valid_i,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  output logic [IDX_W-1:0] victim_o
);
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(SLOTS - 1);

  logic [SLOTS-1:0][IDX_W-1:0] rank_q;

  // unused or freshly filled slots sit at the oldest rank
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SLOTS; i++) rank_q[i] <= OLDEST;
    end else if (touch_i) begin
      for (int i = 0; i < SLOTS; i++) begin
        if (IDX_W'(i) == touch_idx_i)
          rank_q[i] <= '0;
        else if (valid_i[i] && (rank_q[i] < rank_q[touch_idx_i]))
          rank_q[i] <= rank_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_o = '0;
    for (int i = 0; i < SLOTS; i++)
      if (valid_i[i] && (rank_q[i] == OLDEST)) victim_o = IDX_W'(i);
  end

  AST_MRU_AFTER_TOUCH: assert property (@(posedge clk) disable iff (rst)
    touch_i |=> rank_q[$past(touch_idx_i)] == '0); // R5
  // ranks of a full cache form a permutation, so the oldest slot exists
  AST_VICTIM_OLDEST: assert property (@(posedge clk) disable iff (rst)
    (&valid_i) |-> rank_q[victim_o] == OLDEST); // R5
endmodule

// File: rtl/assoc_lru_cache.sv
module assoc_lru_cache
  import fa_cache_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int BLOCK_BYTES = 4,
  parameter int SLOTS       = 4,
  parameter bit WRITE_BACK  = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cpu_req_i,
  input  logic                     cpu_we_i,
  input  logic [ADDR_W-1:0]        cpu_addr_i,
  input  logic [7:0]               cpu_wdata_i,
  output logic                     cpu_ready_o,
  output logic                     cpu_hit_o,
  output logic [7:0]               cpu_rdata_o,
  output logic                     mem_req_o,
  output logic                     mem_we_o,
  output logic [ADDR_W-1:0]        mem_addr_o,
  output logic [8*BLOCK_BYTES-1:0] mem_wdata_o,
  output logic [BLOCK_BYTES-1:0]   mem_wmask_o,
  input  logic [8*BLOCK_BYTES-1:0] mem_rdata_i,
  input  logic                     mem_ready_i
);
  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam int TAG_W = ADDR_W - OFF_W;
  localparam int IDX_W = $clog2(SLOTS);
  localparam int BLK_W = 8 * BLOCK_BYTES;

  cache_state_e                state_q;
  logic [SLOTS-1:0]            valid_q, dirty_q;
  logic [SLOTS-1:0][TAG_W-1:0] tag_q;
  logic [BLK_W-1:0]            data_q [SLOTS];
  logic [IDX_W-1:0]            vic_q;
  logic                        missed_q;

  logic [TAG_W-1:0] req_tag;
  logic [OFF_W-1:0] req_off;
  logic [SLOTS-1:0] hit_vec;
  logic             hit, free, accept;
  logic [IDX_W-1:0] hit_idx, free_idx, lru_victim, victim;
  logic [BLK_W-1:0] hit_word, shifted, merged, lane;
  logic [ADDR_W-1:0] req_blk;
  logic             data_we;
  logic [IDX_W-1:0] data_widx;
  logic [BLK_W-1:0] data_wval;

  assign req_tag = cpu_addr_i[ADDR_W-1:OFF_W];
  assign req_off = cpu_addr_i[OFF_W-1:0];
  assign req_blk = {req_tag, {OFF_W{1'b0}}};
  assign accept  = (state_q == ST_IDLE) && cpu_req_i && !cpu_ready_o;

  fa_tag_match #(.SLOTS(SLOTS), .TAG_W(TAG_W)) u_match (
    .valid_i(valid_q), .tags_i(tag_q), .tag_i(req_tag),
    .hit_vec_o(hit_vec), .hit_o(hit), .hit_idx_o(hit_idx),
    .free_o(free), .free_idx_o(free_idx)
  );

  fa_lru_rank #(.SLOTS(SLOTS)) u_lru (
    .clk(clk), .rst(rst), .valid_i(valid_q),
    .touch_i(accept && hit), .touch_idx_i(hit_idx), .victim_o(lru_victim)
  );

  assign victim   = free ? free_idx : lru_victim;
  assign hit_word = data_q[hit_idx];
  assign shifted  = hit_word >> (8 * int'(req_off));
  assign lane     = BLK_W'(cpu_wdata_i) << (8 * int'(req_off));
  assign merged   = (hit_word & ~(BLK_W'(8'hFF) << (8 * int'(req_off)))) | lane;

  // single write port on the data array
  assign data_we   = (accept && hit && cpu_we_i) || ((state_q == ST_FETCH) && mem_ready_i);
  assign data_widx = (state_q == ST_FETCH) ? vic_q : hit_idx;
  assign data_wval = (state_q == ST_FETCH) ? mem_rdata_i : merged;

  always_ff @(posedge clk) begin
    if (data_we) data_q[data_widx] <= data_wval;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      valid_q     <= '0;
      dirty_q     <= '0;
      tag_q       <= '0;
      vic_q       <= '0;
      missed_q    <= 1'b0;
      cpu_ready_o <= 1'b0;
      cpu_hit_o   <= 1'b0;
      cpu_rdata_o <= '0;
      mem_req_o   <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      mem_wmask_o <= '0;
    end else begin
      cpu_ready_o <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept) begin
          if (hit && (!cpu_we_i || WRITE_BACK)) begin
            if (cpu_we_i) dirty_q[hit_idx] <= 1'b1;
            else          cpu_rdata_o      <= shifted[7:0];
            cpu_ready_o <= 1'b1;
            cpu_hit_o   <= !missed_q;
            missed_q    <= 1'b0;
          end else if (cpu_we_i && !WRITE_BACK) begin
            // write-through: send the byte, no allocation on a miss
            missed_q    <= !hit;
            mem_req_o   <= 1'b1;
            mem_we_o    <= 1'b1;
            mem_addr_o  <= req_blk;
            mem_wdata_o <= lane;
            mem_wmask_o <= BLOCK_BYTES'(1) << req_off;
            state_q     <= ST_WRITE;
          end else begin
            missed_q  <= 1'b1;
            vic_q     <= victim;
            mem_req_o <= 1'b1;
            if (WRITE_BACK && valid_q[victim] && dirty_q[victim]) begin
              mem_we_o    <= 1'b1;
              mem_addr_o  <= {tag_q[victim], {OFF_W{1'b0}}};
              mem_wdata_o <= data_q[victim];
              mem_wmask_o <= '1;
              state_q     <= ST_EVICT;
            end else begin
              mem_we_o    <= 1'b0;
              mem_addr_o  <= req_blk;
              mem_wmask_o <= '0;
              state_q     <= ST_FETCH;
            end
          end
        end
        ST_EVICT: if (mem_ready_i) begin
          dirty_q[vic_q] <= 1'b0;
          mem_we_o       <= 1'b0;
          mem_addr_o     <= req_blk;
          mem_wmask_o    <= '0;
          state_q        <= ST_FETCH;
        end
        ST_FETCH: if (mem_ready_i) begin
          // refill, then replay the held request as a hit
          mem_req_o      <= 1'b0;
          valid_q[vic_q] <= 1'b1;
          dirty_q[vic_q] <= 1'b0;
          tag_q[vic_q]   <= req_tag;
          state_q        <= ST_IDLE;
        end
        ST_WRITE: if (mem_ready_i) begin
          mem_req_o   <= 1'b0;
          mem_we_o    <= 1'b0;
          cpu_ready_o <= 1'b1;
          cpu_hit_o   <= !missed_q;
          missed_q    <= 1'b0;
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    cpu_req_i |-> $onehot0(hit_vec)); // R3
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
    cpu_ready_o |=> !cpu_ready_o); // R9
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o))); // R10

  if (WRITE_BACK) begin : g_wb_chk
    AST_WB_HIT_QUIET: assert property (@(posedge clk) disable iff (rst)
      (accept && hit && cpu_we_i) |=> !mem_req_o); // R6
  end else begin : g_wt_chk
    AST_WT_CLEAN: assert property (@(posedge clk) disable iff (rst)
      dirty_q == '0); // R8
  end
endmodule

// File: tb/test_assoc_lru_cache.sv
`timescale 1ns/1ps
module test_assoc_lru_cache;
  typedef struct {
    bit         we;
    bit         hit;
    logic [7:0] data;
    string      rq;
  } exp_t;

  logic clk = 1'b0;
  logic rst;
  always #4 clk = ~clk;

  // unit 0: write-back, unit 1: write-through
  logic        req [2], we [2], ready [2], hit [2];
  logic [5:0]  addr [2], maddr [2];
  logic [7:0]  wdata [2], rdata [2];
  logic        mreq [2], mwe [2], mready [2];
  logic [31:0] mwdata [2], mrdata [2];
  logic [3:0]  mwmask [2];

  int n_checks = 0;
  int n_errors = 0;
  int miss_cnt [2];
  exp_t q0 [$];
  exp_t q1 [$];
  logic [3:0] ref_tags [2][4];
  int         ref_cnt [2];
  logic [7:0] shadow [2][64];

  assoc_lru_cache #(.WRITE_BACK(1'b1)) i_assoc_lru_cache (
    .clk(clk), .rst(rst), .cpu_req_i(req[0]), .cpu_we_i(we[0]), .cpu_addr_i(addr[0]),
    .cpu_wdata_i(wdata[0]), .cpu_ready_o(ready[0]), .cpu_hit_o(hit[0]), .cpu_rdata_o(rdata[0]),
    .mem_req_o(mreq[0]), .mem_we_o(mwe[0]), .mem_addr_o(maddr[0]), .mem_wdata_o(mwdata[0]),
    .mem_wmask_o(mwmask[0]), .mem_rdata_i(mrdata[0]), .mem_ready_i(mready[0]));

  assoc_lru_cache #(.WRITE_BACK(1'b0)) i_assoc_lru_cache_wt (
    .clk(clk), .rst(rst), .cpu_req_i(req[1]), .cpu_we_i(we[1]), .cpu_addr_i(addr[1]),
    .cpu_wdata_i(wdata[1]), .cpu_ready_o(ready[1]), .cpu_hit_o(hit[1]), .cpu_rdata_o(rdata[1]),
    .mem_req_o(mreq[1]), .mem_we_o(mwe[1]), .mem_addr_o(maddr[1]), .mem_wdata_o(mwdata[1]),
    .mem_wmask_o(mwmask[1]), .mem_rdata_i(mrdata[1]), .mem_ready_i(mready[1]));

  function automatic logic [7:0] init_byte(int a);
    return 8'(a * 7 + 3);
  endfunction

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // memory models, 2-cycle latency
  for (genvar u = 0; u < 2; u++) begin : g_mem
    logic [7:0] arr [64];
    int wr_cnt;
    initial begin
      for (int a = 0; a < 64; a++) arr[a] = init_byte(a);
      wr_cnt = 0;
      mready[u] = 1'b0;
      mrdata[u] = '0;
      forever begin
        @(negedge clk);
        mready[u] = 1'b0;
        if (mreq[u] && !rst) begin
          chk(maddr[u][1:0] == 2'b00, "R10", "memory address alignment", maddr[u][1:0], 0);
          repeat (2) @(negedge clk);
          if (mwe[u]) begin
            wr_cnt++;
            for (int b = 0; b < 4; b++)
              if (mwmask[u][b]) arr[{maddr[u][5:2], 2'(b)}] = mwdata[u][8*b +: 8];
          end else begin
            for (int b = 0; b < 4; b++) mrdata[u][8*b +: 8] = arr[{maddr[u][5:2], 2'(b)}];
          end
          mready[u] = 1'b1;
        end
      end
    end
  end

  task automatic model_reset();
    for (int u = 0; u < 2; u++) begin
      ref_cnt[u] = 0;
      for (int a = 0; a < 64; a++) shadow[u][a] = init_byte(a);
    end
  endtask

  // recency-list model: index 0 is most recent
  task automatic model_access(int u, bit w, logic [5:0] a, logic [7:0] d, output bit exp_hit);
    int pos;
    logic [3:0] t;
    t = a[5:2];
    pos = -1;
    for (int i = 0; i < ref_cnt[u]; i++) if (ref_tags[u][i] == t) pos = i;
    exp_hit = (pos >= 0);
    if (!(w && u == 1 && pos < 0)) begin
      if (pos < 0) begin
        if (ref_cnt[u] < 4) begin pos = ref_cnt[u]; ref_cnt[u]++; end
        else pos = 3;
      end
      for (int i = pos; i > 0; i--) ref_tags[u][i] = ref_tags[u][i-1];
      ref_tags[u][0] = t;
    end
    if (w) shadow[u][a] = d;
  endtask

  // driver: push expectation, drive, wait for completion
  task automatic access(int u, bit w, logic [5:0] a, logic [7:0] d, string rq);
    exp_t e;
    bit eh;
    int cyc;
    model_access(u, w, a, d, eh);
    e.we = w; e.hit = eh; e.data = shadow[u][a]; e.rq = rq;
    if (u == 0) q0.push_back(e); else q1.push_back(e);
    @(negedge clk);
    req[u] = 1'b1; we[u] = w; addr[u] = a; wdata[u] = d;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!ready[u]);
    req[u] = 1'b0;
    if (eh && (!w || u == 0)) chk(cyc == 1, "R9", "hit latency in cycles", cyc, 1);
  endtask

  // monitor: pop and compare on each ready pulse
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      for (int u = 0; u < 2; u++) begin
        if (ready[u]) begin
          if ((u == 0 ? q0.size() : q1.size()) == 0) begin
            chk(1'b0, "R9", "unexpected ready pulse", 1, 0);
          end else begin
            e = (u == 0) ? q0.pop_front() : q1.pop_front();
            if (!hit[u]) miss_cnt[u]++;
            chk(hit[u] == e.hit, e.rq, "hit flag (R3)", hit[u], e.hit);
            if (!e.we) chk(rdata[u] == e.data, e.rq, "read byte (R1)", rdata[u], e.data);
          end
        end
      end
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
    miss_cnt[0] = 0;
    miss_cnt[1] = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", "run timed out", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    int wc;
    int seq1 [8] = '{0, 2, 4, 10, 20, 16, 0, 2};
    int seq2 [8] = '{0, 2, 2, 0, 16, 20, 10, 4};
    for (int u = 0; u < 2; u++) begin
      req[u] = 0; we[u] = 0; addr[u] = 0; wdata[u] = 0;
    end
    do_reset();
    // R2: cold state after reset
    for (int u = 0; u < 2; u++) begin
      chk(ready[u] == 1'b0, "R2", "ready after reset", ready[u], 0);
      chk(mreq[u] == 1'b0, "R2", "mem_req after reset", mreq[u], 0);
    end

    // R5: first sequence, 6 misses, block 0 evicted by 16
    foreach (seq1[i]) access(0, 1'b0, 6'(seq1[i]), 8'h00, "R5");
    @(negedge clk);
    chk(miss_cnt[0] == 6, "R5", "misses in first sequence", miss_cnt[0], 6);

    // R4: reordered sequence from cold, 5 misses
    do_reset();
    foreach (seq2[i]) access(0, 1'b0, 6'(seq2[i]), 8'h00, "R4");
    @(negedge clk);
    chk(miss_cnt[0] == 5, "R4", "misses in reordered sequence", miss_cnt[0], 5);

    // R6: write hit stays in cache
    access(0, 1'b0, 6'd16, 8'h00, "R6");
    wc = g_mem[0].wr_cnt;
    access(0, 1'b1, 6'd17, 8'hA1, "R6");
    @(negedge clk);
    chk(g_mem[0].wr_cnt == wc, "R6", "memory writes after write hit", g_mem[0].wr_cnt, wc);
    chk(g_mem[0].arr[17] == init_byte(17), "R6", "memory byte before eviction",
        g_mem[0].arr[17], init_byte(17));
    // evict everything, dirty block goes back
    access(0, 1'b0, 6'd32, 8'h00, "R6");
    access(0, 1'b0, 6'd36, 8'h00, "R6");
    access(0, 1'b0, 6'd40, 8'h00, "R6");
    access(0, 1'b0, 6'd44, 8'h00, "R6");
    @(negedge clk);
    chk(g_mem[0].arr[17] == 8'hA1, "R6", "memory byte after dirty eviction", g_mem[0].arr[17], 8'hA1);
    chk(g_mem[0].wr_cnt == wc + 1, "R6", "whole-block write-backs", g_mem[0].wr_cnt, wc + 1);
    access(0, 1'b0, 6'd17, 8'h00, "R6");

    // R7: write-back write miss allocates and merges
    access(0, 1'b1, 6'd50, 8'h77, "R7");
    access(0, 1'b0, 6'd50, 8'h00, "R7");
    access(0, 1'b0, 6'd49, 8'h00, "R7");
    @(negedge clk);
    chk(g_mem[0].arr[50] == init_byte(50), "R7", "memory untouched before eviction",
        g_mem[0].arr[50], init_byte(50));

    // R8: write-through unit
    wc = g_mem[1].wr_cnt;
    access(1, 1'b1, 6'd8, 8'h33, "R8");
    @(negedge clk);
    chk(g_mem[1].wr_cnt == wc + 1, "R8", "memory writes after write miss", g_mem[1].wr_cnt, wc + 1);
    chk(g_mem[1].arr[8] == 8'h33, "R8", "memory byte after write miss", g_mem[1].arr[8], 8'h33);
    access(1, 1'b0, 6'd8, 8'h00, "R8");
    access(1, 1'b1, 6'd9, 8'h44, "R8");
    @(negedge clk);
    chk(g_mem[1].wr_cnt == wc + 2, "R8", "memory writes after write hit", g_mem[1].wr_cnt, wc + 2);
    chk(g_mem[1].arr[9] == 8'h44, "R8", "memory byte after write hit", g_mem[1].arr[9], 8'h44);
    chk(g_mem[1].arr[10] == init_byte(10), "R8", "neighbour byte untouched",
        g_mem[1].arr[10], init_byte(10));
    access(1, 1'b0, 6'd9, 8'h00, "R8");

    repeat (4) @(negedge clk);
    chk(q0.size() == 0 && q1.size() == 0, "R9", "pending expectations", q0.size() + q1.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule